// File: doc/BRIEF.md
# Byte-Lane Memory Access Sequencer

This block sits between a 16-bit processor core and a 16-bit synchronous memory bus. A core request names a 20-bit byte address, which covers 1,048,576 bytes, together with a byte or word size, a direction and write data. The block turns each request into one or two bus cycles. It places every byte on the bus half that matches its address parity and keeps words in little-endian order, so the low-order byte sits at the lower address.

A word at an even address needs one bus cycle. A word at an odd address is split into two byte cycles. The first cycle uses the upper lane at the original address and the second uses the lower lane at the next byte address. Read bytes are reassembled before the result is returned. The core sees a one-cycle completion pulse and takes read data from the result bus in that same cycle. A request is taken only while the block is idle.

Top module: `lane_seq_top`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `mem_req`=0 and `req_done`=0.
- R2: A request with `req_valid`=1 is taken at a clock edge only when `req_ready`=1. A request presented while busy has no effect on the bus cycles or the result.
- R3: A byte access at an even address makes one bus cycle with `mem_be_lo`=1 and `mem_be_hi`=0. On a write, the byte appears on `mem_wdata[7:0]` and bits 15..8 are zero. `mem_addr` is the byte address shifted right by one.
- R4: A byte access at an odd address makes one bus cycle with `mem_be_hi`=1 and `mem_be_lo`=0. On a write, the byte appears on `mem_wdata[15:8]` and bits 7..0 are zero.
- R5: A word access at an even address makes one bus cycle with both enables set. On a write, `mem_wdata` equals `req_wdata`.
- R6: A word access at an odd address A makes two bus cycles. The first uses the upper lane only at word address A>>1 and carries `req_wdata[7:0]` in bits 15..8. The second uses the lower lane only at word address ((A+1) mod 2^20)>>1 and carries `req_wdata[15:8]` in bits 7..0. Byte address 0xFFFFF therefore wraps to word address 0.
- R7: A byte read returns the addressed lane's byte in `req_rdata[7:0]`, with bits 15..8 zero.
- R8: A word read returns the lower-address byte in `req_rdata[7:0]` and the higher-address byte in `req_rdata[15:8]`. This holds for both the aligned case and the split case.
- R9: `mem_req` stays high, and address, enables, write flag and write data stay unchanged, until the cycle in which `mem_ack` is high.
- R10: `req_done` is high for exactly one clock, in the cycle after the acknowledge of the last bus cycle of a request. `req_ready` is high in that same cycle.
- R11: `mem_we` equals the request's write flag in every bus cycle of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core presents a request |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data, byte requests use bits 7..0 |
| req_ready | output | 1 | Block idle, a request will be taken |
| req_rdata | output | 16 | Read result, valid while `req_done` is high |
| req_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Bus cycle active |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | 19 | Word address |
| mem_be_hi | output | 1 | Upper lane (bits 15..8) enable |
| mem_be_lo | output | 1 | Lower lane (bits 7..0) enable |
| mem_wdata | output | 16 | Bus write data |
| mem_rdata | input | 16 | Bus read data, sampled with `mem_ack` |
| mem_ack | input | 1 | Memory completes the current bus cycle |

## Verification
The hardest case to reach is a split word access whose two halves are separated by memory wait states. In that case the low byte must be held across a stalled second cycle while a new request is already pushing at the core port. The stimulus handles this by holding acknowledges back at pseudo-random intervals and by raising `req_valid` with unrelated fields while the block is busy. It also places requests in the completion cycle itself, so a new request follows with no idle gap. Directed accesses at byte address 0xFFFFF make the second half of a split word wrap to word address 0.

// File: rtl/lane_seq_pkg.sv
package lane_seq_pkg;

    localparam int ADDR_W  = 20;
    localparam int LANE_W  = 8;
    localparam int LANES   = 2;
    localparam int DATA_W  = LANE_W * LANES;
    localparam int SEL_W   = $clog2(LANES);
    localparam int WADDR_W = ADDR_W - SEL_W;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_FIRST  = 2'd1,
        SEQ_SECOND = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              word;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } core_req_t;

    typedef struct packed {
        logic [WADDR_W-1:0] waddr;
        logic               be_hi;
        logic               be_lo;
        logic [DATA_W-1:0]  wdata;
    } bus_cyc_t;

    // A word that starts on an odd byte straddles two bus words.
    function automatic logic needs_split(logic word, logic [ADDR_W-1:0] addr);
        return word & addr[0];
    endfunction

    function automatic logic [ADDR_W-1:0] next_byte(logic [ADDR_W-1:0] addr);
        return addr + ADDR_W'(1);
    endfunction

endpackage

// File: rtl/lane_seq_ctrl.sv
module lane_seq_ctrl
    import lane_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  core_req_t  req_in,
    input  logic       mem_ack,
    output seq_state_e state,
    output core_req_t  req_q,
    output logic       done_q
);

    logic split;
    assign split = needs_split(req_q.word, req_q.addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            req_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        req_q <= req_in;
                        state <= SEQ_FIRST;
                    end
                end
                SEQ_FIRST: begin
                    if (mem_ack) begin
                        if (split) begin
                            state <= SEQ_SECOND;
                        end else begin
                            state  <= SEQ_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                SEQ_SECOND: begin
                    if (mem_ack) begin
                        state  <= SEQ_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R2: a request seen while idle always starts a bus cycle next
    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && req_valid) |=> (state == SEQ_FIRST));

    // R6: only a straddling word ever reaches the second phase
    p_second_only_split_r6: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_SECOND) |-> split);

    // R9: no progress without an acknowledge
    p_hold_state_r9: assert property (@(posedge clk) disable iff (rst)
        (state != SEQ_IDLE && !mem_ack) |=> ($stable(state) && $stable(req_q)));

endmodule

// File: rtl/lane_seq_plan.sv
module lane_seq_plan
    import lane_seq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              word,
    input  logic [DATA_W-1:0] wdata,
    input  logic              second,
    output bus_cyc_t          cyc
);

    logic [ADDR_W-1:0] eff_addr;
    logic              aligned_word;
    logic [LANE_W-1:0] mv_byte;
    logic [LANES-1:0]  lane_en;

    always_comb begin
        eff_addr     = second ? next_byte(addr) : addr;
        aligned_word = word & ~addr[0];
        // First phase carries the low byte, second phase the high byte.
        mv_byte      = second ? wdata[DATA_W-1 -: LANE_W] : wdata[LANE_W-1:0];
        lane_en[1]   = ~second & (addr[0] | word);
        lane_en[0]   = second | ~addr[0];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign cyc.wdata[i*LANE_W +: LANE_W] =
            aligned_word ? wdata[i*LANE_W +: LANE_W] :
            (lane_en[i] ? mv_byte : '0);
    end

    assign cyc.waddr = eff_addr[ADDR_W-1:SEL_W];
    assign cyc.be_hi = lane_en[1];
    assign cyc.be_lo = lane_en[0];

endmodule

// File: rtl/lane_seq_gather.sv
module lane_seq_gather
    import lane_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  logic              addr_lsb,
    input  logic              word,
    input  logic              write,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rdata
);

    logic [LANE_W-1:0] lane_b [LANES];
    logic [LANE_W-1:0] hold_q;
    logic              fire;
    logic              split;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_b[i] = mem_rdata[i*LANE_W +: LANE_W];
    end

    assign fire  = (state != SEQ_IDLE) && mem_ack && !write;
    assign split = word & addr_lsb;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            hold_q <= '0;
        end else if (fire) begin
            if (state == SEQ_SECOND) begin
                rdata <= {lane_b[0], hold_q};
            end else if (split) begin
                hold_q <= lane_b[1];
            end else if (word) begin
                rdata <= mem_rdata;
            end else begin
                rdata <= {{(DATA_W-LANE_W){1'b0}}, lane_b[addr_lsb]};
            end
        end
    end

    // R7: a finished byte read leaves the upper half clear
    p_byte_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && state == SEQ_FIRST && !word) |=> (rdata[DATA_W-1:LANE_W] == '0));

    // R8: the split low byte comes from the upper lane of the first cycle
    p_split_low_byte_r8: assert property (@(posedge clk) disable iff (rst)
        (fire && state == SEQ_FIRST && split) |=> (hold_q == $past(mem_rdata[DATA_W-1:LANE_W])));

endmodule

// File: rtl/lane_seq_top.sv
module lane_seq_top
    import lane_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_word,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic [DATA_W-1:0]  req_rdata,
    output logic               req_done,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_addr,
    output logic               mem_be_hi,
    output logic               mem_be_lo,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_ack
);

    core_req_t  req_in;
    core_req_t  req_q;
    seq_state_e state;
    bus_cyc_t   cyc;
    logic       done_q;

    assign req_in = '{addr: req_addr, word: req_word, write: req_write, wdata: req_wdata};

    lane_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .mem_ack   (mem_ack),
        .state     (state),
        .req_q     (req_q),
        .done_q    (done_q)
    );

    lane_seq_plan u_plan (
        .addr   (req_q.addr),
        .word   (req_q.word),
        .wdata  (req_q.wdata),
        .second (state == SEQ_SECOND),
        .cyc    (cyc)
    );

    lane_seq_gather u_gather (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .addr_lsb  (req_q.addr[0]),
        .word      (req_q.word),
        .write     (req_q.write),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .rdata     (req_rdata)
    );

    assign req_ready = (state == SEQ_IDLE);
    assign req_done  = done_q;
    assign mem_req   = (state != SEQ_IDLE);
    assign mem_we    = mem_req & req_q.write;
    assign mem_addr  = cyc.waddr;
    assign mem_be_hi = mem_req & cyc.be_hi;
    assign mem_be_lo = mem_req & cyc.be_lo;
    assign mem_wdata = (mem_req && req_q.write) ? cyc.wdata : '0;

    // R3: every bus cycle enables at least one lane
    p_lane_enable_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_be_hi || mem_be_lo));

    // R4: a byte request touches exactly one lane
    p_byte_one_lane_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !req_q.word) |-> (mem_be_hi != mem_be_lo));

    // R6: a straddling word starts on the upper lane alone
    p_split_upper_first_r6: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_FIRST && needs_split(req_q.word, req_q.addr)) |-> (mem_be_hi && !mem_be_lo));

    // R9: bus cycle frozen until acknowledged
    p_hold_bus_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be_hi)
                                   && $stable(mem_be_lo) && $stable(mem_we) && $stable(mem_wdata)));

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done);

    // R10: completion only follows an acknowledged bus cycle
    p_done_follows_ack_r10: assert property (@(posedge clk) disable iff (rst)
        req_done |-> $past(mem_req && mem_ack));

endmodule

// File: tb/sim_lane_seq_top.sv
`timescale 1ns/1ps
module sim_lane_seq_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [19:0] req_addr;
    logic        req_word;
    logic        req_write;
    logic [15:0] req_wdata;
    logic        req_ready;
    logic [15:0] req_rdata;
    logic        req_done;
    logic        mem_req;
    logic        mem_we;
    logic [18:0] mem_addr;
    logic        mem_be_hi;
    logic        mem_be_lo;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_ack;

    always #4 clk = ~clk;

    lane_seq_top u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_rdata(req_rdata), .req_done(req_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be_hi(mem_be_hi), .mem_be_lo(mem_be_lo), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [15:0] rd_pat(logic [18:0] wa);
        logic [15:0] t;
        t = wa[15:0] * 16'd40503;
        return t ^ {13'h0, wa[18:16]} ^ 16'h5A3C;
    endfunction

    // Memory answers with a pattern of the word address while acknowledging.
    always_comb mem_rdata = mem_ack ? rd_pat(mem_addr) : 16'hBEEF;

    typedef struct {
        logic [18:0] wa;
        logic        hi;
        logic        lo;
        logic [15:0] wd;
        logic        we;
        int          rmode; // 0 whole word, 1 lane to result low byte, 2 lane to result high byte
    } cyc_t;

    typedef struct {
        logic [19:0] a;
        logic        w;
        logic        wr;
        logic [15:0] d;
    } rq_t;

    cyc_t q[$];
    rq_t  stim[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    logic        m_done;
    logic [15:0] m_res;
    logic [15:0] m_rdata;
    logic        m_write;
    logic        m_rd_done;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic void build(rq_t r);
        cyc_t c;
        logic [19:0] a2;
        c.we = r.wr;
        c.wa = r.a[19:1];
        if (!r.w && !r.a[0]) begin
            c.hi = 0; c.lo = 1; c.wd = {8'h00, r.d[7:0]}; c.rmode = 1; q.push_back(c);
        end else if (!r.w) begin
            c.hi = 1; c.lo = 0; c.wd = {r.d[7:0], 8'h00}; c.rmode = 1; q.push_back(c);
        end else if (!r.a[0]) begin
            c.hi = 1; c.lo = 1; c.wd = r.d; c.rmode = 0; q.push_back(c);
        end else begin
            c.hi = 1; c.lo = 0; c.wd = {r.d[7:0], 8'h00}; c.rmode = 1; q.push_back(c);
            a2 = r.a + 20'd1;
            c.wa = a2[19:1];
            c.hi = 0; c.lo = 1; c.wd = {8'h00, r.d[15:8]}; c.rmode = 2; q.push_back(c);
        end
    endfunction

    initial begin
        logic [15:0] lfsr;
        logic        pv, pack;
        rq_t         pr, r;
        cyc_t        c;
        logic [15:0] pat;
        logic [7:0]  lb;
        int          cycles;

        lfsr = 16'hACE1;
        rst = 1; req_valid = 0; req_addr = 0; req_word = 0; req_write = 0; req_wdata = 0; mem_ack = 0;
        m_done = 0; m_res = 0; m_rdata = 0; m_write = 0; m_rd_done = 0;

        // Directed accesses: all four placements, both directions, top-of-space wrap.
        stim.push_back('{20'h00010, 1'b0, 1'b1, 16'h0011}); // R3
        stim.push_back('{20'h00011, 1'b0, 1'b1, 16'h0022}); // R4
        stim.push_back('{20'h00100, 1'b1, 1'b1, 16'hA1B2}); // R5
        stim.push_back('{20'h00201, 1'b1, 1'b1, 16'hC3D4}); // R6
        stim.push_back('{20'hFFFFF, 1'b1, 1'b1, 16'hE5F6}); // R6 wrap
        stim.push_back('{20'h00010, 1'b0, 1'b0, 16'h0000}); // R7
        stim.push_back('{20'h00011, 1'b0, 1'b0, 16'h0000}); // R7
        stim.push_back('{20'hFFFFF, 1'b0, 1'b0, 16'h0000}); // R7
        stim.push_back('{20'h00000, 1'b1, 1'b0, 16'h0000}); // R8
        stim.push_back('{20'h00201, 1'b1, 1'b0, 16'h0000}); // R8 split
        stim.push_back('{20'hFFFFF, 1'b1, 1'b0, 16'h0000}); // R8 split wrap
        for (int i = 0; i < 400; i++) begin
            r.a  = 20'($urandom);
            r.w  = 1'($urandom);
            r.wr = 1'($urandom);
            r.d  = 16'($urandom);
            stim.push_back(r);
        end

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: idle state out of reset
        chk("R1", "req_ready", 32'(req_ready), 32'd1);
        chk("R1", "mem_req",   32'(mem_req),   32'd0);
        chk("R1", "req_done",  32'(req_done),  32'd0);
        rst = 0;
        pv = 0; pack = 0; pr = '{20'h0, 1'b0, 1'b0, 16'h0};
        cycles = 0;

        forever begin
            @(negedge clk);
            cycles++;
            // Model the edge just passed with the inputs driven before it.
            m_done = 0;
            if (q.size() > 0 && pack) begin
                c = q.pop_front();
                pat = rd_pat(c.wa);
                lb = c.hi ? pat[15:8] : pat[7:0];
                if (c.rmode == 0) m_res = pat;
                else if (c.rmode == 1) m_res[7:0] = lb;
                else m_res[15:8] = lb;
                if (q.size() == 0) begin
                    m_done = 1;
                    m_rdata = m_res;
                    m_rd_done = !m_write;
                end
            end else if (q.size() == 0 && pv) begin
                m_res = 16'h0000;
                m_write = pr.wr;
                build(pr);
            end

            // Compare every output against the model.
            chk("R2", "req_ready", 32'(req_ready), 32'(q.size() == 0));
            chk("R9", "mem_req",   32'(mem_req),   32'(q.size() != 0));
            chk("R10", "req_done", 32'(req_done),  32'(m_done));
            if (m_done && m_rd_done)
                chk("R7 R8", "req_rdata", 32'(req_rdata), 32'(m_rdata));
            if (q.size() != 0) begin
                chk("R6", "mem_addr",  32'(mem_addr),  32'(q[0].wa));
                chk("R3 R4 R5", "mem_be_hi", 32'(mem_be_hi), 32'(q[0].hi));
                chk("R3 R4 R5", "mem_be_lo", 32'(mem_be_lo), 32'(q[0].lo));
                chk("R11", "mem_we", 32'(mem_we), 32'(q[0].we));
                if (q[0].we)
                    chk("R3 R4 R5 R6", "mem_wdata", 32'(mem_wdata), 32'(q[0].wd));
            end

            if (cycles > 100000) begin
                n_bad++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
                break;
            end
            if (stim.size() == 0 && q.size() == 0 && !m_done) break;

            // Drive the next inputs.
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pack = (cycles < 150) ? 1'b1 : (lfsr[3] | lfsr[7]);
            if (q.size() == 0 && stim.size() > 0 && (lfsr[0] | lfsr[1])) begin
                pr = stim.pop_front();
                pv = 1;
            end else if (q.size() != 0 && lfsr[2]) begin
                // R2: request while busy, must be ignored
                pr = '{20'($urandom), 1'($urandom), 1'($urandom), 16'($urandom)};
                pv = 1;
            end else begin
                pr = '{20'($urandom), 1'($urandom), 1'($urandom), 16'($urandom)};
                pv = 0;
            end
            req_valid = pv;
            req_addr  = pr.a;
            req_word  = pr.w;
            req_write = pr.wr;
            req_wdata = pr.d;
            mem_ack   = pack;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule